// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Byte Error Flags

This block recovers asynchronous serial characters from a single input line. A 16x sample tick, produced elsewhere, paces the receiver. It finds a start bit and checks it at mid-bit. It then takes the data bits least significant bit first and checks the parity bit and the stop bits. The finished character goes into a one-entry holding register along with that character's own parity, framing and break flags.

A run-time format word sets the shape of each character. It selects the word length (5 to 8 bits), whether parity is present, the parity kind (odd, even, forced one, forced zero) and the stop length (one, or a longer setting that means two stop bits, or one and a half for 5-bit words). A five-bit status word reports the following: whether a byte is waiting, overrun, parity error, framing error and break. The four error bits stay set until software issues a status read strobe. A byte read strobe empties the holding register. If a new character lands while the register is still full, the new character replaces the old one and overrun is flagged.

Top module: `serial_rx_status`

## Requirements
- R1: After reset, `rx_valid` is 0 and `line_status` is 0.
- R2: `fmt[1:0]` sets the data bit count as 5 + value. Bits arrive least significant first. Bits of `rx_data` above the word length read as 0.
- R3: `fmt[3]` set means a parity bit follows the data. With `fmt[5:4]` = 0 the count of ones over the data and parity must be odd, and with 1 it must be even. A mismatch sets `byte_err[0]` and `line_status[2]`.
- R4: With parity enabled, `fmt[5:4]` = 2 expects a parity bit of 1 and 3 expects a parity bit of 0. Any other received value is a parity error.
- R5: A low first stop bit sets `byte_err[1]` and `line_status[3]`, and the character is still delivered.
- R6: When the line stays low from the start bit through the last stop sample, `byte_err[2]` and `line_status[4]` are set, and framing error is set as well.
- R7: With `fmt[2]` = 1 the receiver takes a second stop sample one bit time after the first, or three quarters of a bit time after it for 5-bit words. A high value there means no break.
- R8: A low pulse that is over before the mid-bit check of the start bit is ignored, and no byte is delivered.
- R9: If a character completes while `rx_valid` is 1 and there is no byte read in that cycle, `line_status[1]` is set and the new byte replaces the old one.
- R10: `line_status[0]` mirrors `rx_valid`. A `rd_byte` strobe clears it unless a character completes in the same cycle.
- R11: A `rd_status` strobe clears `line_status[4:1]`. An error that arrives in the same cycle as the strobe stays set.
- R12: After a character whose last stop sample was low, no new start is accepted until the line has been seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Serial input, idles high |
| tick16 | input | 1 | One-cycle sample enable at 16x the bit rate |
| fmt | input | 6 | Character format: {parity kind[1:0], parity on, long stop, length[1:0]} |
| rd_byte | input | 1 | Strobe that empties the holding register |
| rd_status | input | 1 | Strobe that clears the error bits of the status |
| rx_data | output | 8 | Held character |
| rx_valid | output | 1 | Holding register full |
| byte_err | output | 3 | Flags of the held character: {break, framing, parity} |
| line_status | output | 5 | {break, framing, parity, overrun, data ready} |

## Verification
Two things can fall in the same clock cycle: a character completing with an error, and a status read that clears error bits. To provoke this, the bench holds `rd_status` high for the whole of a frame whose stop bit is low. It releases the strobe at the first falling clock edge where `rx_valid` shows up. So the completion cycle is certain to have seen the read. The result passes only if the framing bit is still set afterwards and a later read clears it. Overrun, where a completion meets a full register, is judged from the status and from which byte remains.

// File: rtl/srx_pkg.sv
package srx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP1,
      ST_STOP2,
      ST_WAITHI
   } rx_state_e;

   // field order follows the format word, msb first
   typedef struct packed {
      logic [1:0] par_sel;
      logic       par_en;
      logic       stop_ext;
      logic [1:0] len_sel;
   } rx_fmt_t;

   localparam int unsigned FMT_W = 6;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned ERR_W = 3;
   localparam int unsigned STAT_W = 5;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   if (STAGES < 1) begin : g_bad_stages
      $error("srx_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_one
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b1;
         else        q <= din;
      end
      assign dout = q;
   end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '1;
         else        q <= {q[STAGES-2:0], din};
      end
      assign dout = q[STAGES-1];
   end

endmodule

// File: rtl/srx_framer.sv
module srx_framer
   import srx_pkg::*;
#(
   parameter int unsigned OS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx_s,
   input  rx_fmt_t           fmt,
   output logic              done,
   output logic [BYTE_W-1:0] data,
   output logic              pe,
   output logic              fe,
   output logic              brk
);

   localparam int unsigned CNT_W = $clog2(OS);
   localparam logic [CNT_W-1:0] MID_LAST  = CNT_W'(OS / 2 - 1);
   localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OS - 1);
   localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'((OS * 3) / 4 - 1);

   if (OS < 8 || (OS % 4) != 0) begin : g_bad_os
      $error("srx_framer: OS must be a multiple of 4 and at least 8");
   end

   rx_state_e         st;
   rx_fmt_t           fmt_q;
   logic [CNT_W-1:0]  cnt;
   logic [2:0]        bit_idx;
   logic [BYTE_W-1:0] shreg;
   logic              par_bit;
   logic              all_low;
   logic              stop1_low;

   logic [2:0]        last_idx;
   logic [BYTE_W-1:0] aligned;
   logic              ones_odd;
   logic              par_bad;
   logic [CNT_W-1:0]  stop2_last;

   assign last_idx   = 3'd4 + {1'b0, fmt_q.len_sel};
   assign aligned    = shreg >> (2'd3 - fmt_q.len_sel);
   assign ones_odd   = ^shreg;
   assign stop2_last = (fmt_q.len_sel == 2'd0) ? HALF_LAST : FULL_LAST;

   always_comb begin
      par_bad = 1'b0;
      if (fmt_q.par_en) begin
         unique case (fmt_q.par_sel)
            2'd0:    par_bad = ~(ones_odd ^ par_bit);
            2'd1:    par_bad = ones_odd ^ par_bit;
            2'd2:    par_bad = ~par_bit;
            default: par_bad = par_bit;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         fmt_q     <= '0;
         cnt       <= '0;
         bit_idx   <= '0;
         shreg     <= '0;
         par_bit   <= 1'b0;
         all_low   <= 1'b0;
         stop1_low <= 1'b0;
         done      <= 1'b0;
         data      <= '0;
         pe        <= 1'b0;
         fe        <= 1'b0;
         brk       <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            unique case (st)
               ST_IDLE: begin
                  if (!rx_s) begin
                     st    <= ST_START;
                     cnt   <= '0;
                     fmt_q <= fmt;
                  end
               end
               ST_START: begin
                  if (cnt == MID_LAST) begin
                     if (rx_s) begin
                        st <= ST_IDLE;
                     end else begin
                        st      <= ST_DATA;
                        cnt     <= '0;
                        bit_idx <= '0;
                        shreg   <= '0;
                        par_bit <= 1'b0;
                        all_low <= 1'b1;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_DATA: begin
                  if (cnt == FULL_LAST) begin
                     cnt   <= '0;
                     shreg <= {rx_s, shreg[BYTE_W-1:1]};
                     if (rx_s) all_low <= 1'b0;
                     if (bit_idx == last_idx) begin
                        st <= fmt_q.par_en ? ST_PAR : ST_STOP1;
                     end else begin
                        bit_idx <= bit_idx + 1'b1;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_PAR: begin
                  if (cnt == FULL_LAST) begin
                     cnt     <= '0;
                     par_bit <= rx_s;
                     if (rx_s) all_low <= 1'b0;
                     st <= ST_STOP1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_STOP1: begin
                  if (cnt == FULL_LAST) begin
                     cnt       <= '0;
                     stop1_low <= ~rx_s;
                     if (fmt_q.stop_ext) begin
                        if (rx_s) all_low <= 1'b0;
                        st <= ST_STOP2;
                     end else begin
                        done <= 1'b1;
                        data <= aligned;
                        pe   <= par_bad;
                        fe   <= ~rx_s;
                        brk  <= all_low & ~rx_s;
                        st   <= rx_s ? ST_IDLE : ST_WAITHI;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_STOP2: begin
                  if (cnt == stop2_last) begin
                     cnt  <= '0;
                     done <= 1'b1;
                     data <= aligned;
                     pe   <= par_bad;
                     fe   <= stop1_low;
                     brk  <= all_low & ~rx_s;
                     st   <= rx_s ? ST_IDLE : ST_WAITHI;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: begin
                  if (rx_s) st <= ST_IDLE;
               end
            endcase
         end
      end
   end

   // R6
   brk_has_fe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && brk) |-> fe);

   // R12
   waithi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAITHI && !rx_s) |=> (st == ST_WAITHI));

   // R8
   start_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_START && $past(st) == ST_START && tick && rx_s && cnt == MID_LAST) |=> (st == ST_IDLE));

endmodule

// File: rtl/srx_hold.sv
module srx_hold
   import srx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [BYTE_W-1:0] d_data,
   input  logic              d_pe,
   input  logic              d_fe,
   input  logic              d_brk,
   input  logic              rd_byte,
   input  logic              rd_status,
   output logic [BYTE_W-1:0] rx_data,
   output logic              rx_valid,
   output logic [ERR_W-1:0]  byte_err,
   output logic [STAT_W-1:0] line_status
);

   logic ovr_q, pe_q, fe_q, brk_q;
   logic ovr_now;

   assign ovr_now = done & rx_valid & ~rd_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data  <= '0;
         rx_valid <= 1'b0;
         byte_err <= '0;
      end else if (done) begin
         rx_data  <= d_data;
         rx_valid <= 1'b1;
         byte_err <= {d_brk, d_fe, d_pe};
      end else if (rd_byte) begin
         rx_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_q <= 1'b0;
         pe_q  <= 1'b0;
         fe_q  <= 1'b0;
         brk_q <= 1'b0;
      end else begin
         ovr_q <= (ovr_q & ~rd_status) | ovr_now;
         pe_q  <= (pe_q  & ~rd_status) | (done & d_pe);
         fe_q  <= (fe_q  & ~rd_status) | (done & d_fe);
         brk_q <= (brk_q & ~rd_status) | (done & d_brk);
      end
   end

   assign line_status = {brk_q, fe_q, pe_q, ovr_q, rx_valid};

   // R9
   overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rx_valid && !rd_byte) |=> line_status[1]);

   // R10
   pop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_byte && !done) |=> !rx_valid);

   // R11
   status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_status && !done) |=> (line_status[4:1] == 4'b0000));

   // R11
   error_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && d_fe) |=> line_status[3]);

endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
   import srx_pkg::*;
#(
   parameter int unsigned OS          = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rx_line,
   input  logic                tick16,
   input  logic [FMT_W-1:0]    fmt,
   input  logic                rd_byte,
   input  logic                rd_status,
   output logic [BYTE_W-1:0]   rx_data,
   output logic                rx_valid,
   output logic [ERR_W-1:0]    byte_err,
   output logic [STAT_W-1:0]   line_status
);

   logic              rx_s;
   logic              f_done;
   logic [BYTE_W-1:0] f_data;
   logic              f_pe, f_fe, f_brk;
   rx_fmt_t           fmt_s;

   assign fmt_s = rx_fmt_t'(fmt);

   srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (rx_line),
      .dout  (rx_s)
   );

   srx_framer #(.OS(OS)) u_framer (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick16),
      .rx_s  (rx_s),
      .fmt   (fmt_s),
      .done  (f_done),
      .data  (f_data),
      .pe    (f_pe),
      .fe    (f_fe),
      .brk   (f_brk)
   );

   srx_hold u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .done        (f_done),
      .d_data      (f_data),
      .d_pe        (f_pe),
      .d_fe        (f_fe),
      .d_brk       (f_brk),
      .rd_byte     (rd_byte),
      .rd_status   (rd_status),
      .rx_data     (rx_data),
      .rx_valid    (rx_valid),
      .byte_err    (byte_err),
      .line_status (line_status)
   );

   // R10
   ready_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_status[0] == rx_valid);

endmodule

// File: tb/serial_rx_status_tb.sv
module serial_rx_status_tb;

   localparam int BIT_CLKS = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_line = 1'b1;
   logic       tick16 = 1'b0;
   logic [5:0] fmt = 6'b000011;
   logic       rd_byte = 1'b0;
   logic       rd_status = 1'b0;
   logic [7:0] rx_data;
   logic       rx_valid;
   logic [2:0] byte_err;
   logic [4:0] line_status;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   serial_rx_status u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_line     (rx_line),
      .tick16      (tick16),
      .fmt         (fmt),
      .rd_byte     (rd_byte),
      .rd_status   (rd_status),
      .rx_data     (rx_data),
      .rx_valid    (rx_valid),
      .byte_err    (byte_err),
      .line_status (line_status)
   );

   initial begin
      forever begin
         repeat (3) @(negedge clk);
         tick16 = 1'b1;
         @(negedge clk);
         tick16 = 1'b0;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_bits(input logic [15:0] bits, input int n);
      for (int i = 0; i < n; i++) begin
         rx_line = bits[i];
         repeat (BIT_CLKS) @(negedge clk);
      end
   endtask

   task automatic hold_level(input logic lvl, input int clks);
      rx_line = lvl;
      repeat (clks) @(negedge clk);
   endtask

   task automatic pop_clear;
      rd_byte = 1'b1;
      rd_status = 1'b1;
      @(negedge clk);
      rd_byte = 1'b0;
      rd_status = 1'b0;
   endtask

   task automatic send_byte8(input logic [7:0] d, input logic stop);
      logic [15:0] b;
      b = 16'hFFFF;
      b[0] = 1'b0;
      for (int i = 0; i < 8; i++) b[1+i] = d[i];
      b[9] = stop;
      send_bits(b, 12);
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] vals [3];
      vals[0] = 8'h96;
      vals[1] = 8'h3F;
      vals[2] = 8'h01;
      repeat (5) @(negedge clk);
      chk("R1 valid at reset", {31'b0, rx_valid}, 32'd0);
      chk("R1 status at reset", {27'b0, line_status}, 32'd0);
      rst_n = 1'b1;
      hold_level(1'b1, 2 * BIT_CLKS);

      // R2 R3 R4 sweep: length x parity mode x data x good/bad parity
      for (int len = 0; len < 4; len++) begin
         for (int pm = 0; pm < 5; pm++) begin
            for (int di = 0; di < 3; di++) begin
               for (int bad = 0; bad < ((pm == 0) ? 1 : 2); bad++) begin
                  int          n;
                  logic [7:0]  d;
                  logic        p;
                  logic [15:0] b;
                  int          cnt;
                  n = 5 + len;
                  d = vals[di] & 8'((9'h100 >> (3 - len)) - 9'd1);
                  case (pm)
                     1: p = ~(^d);
                     2: p = ^d;
                     3: p = 1'b1;
                     default: p = 1'b0;
                  endcase
                  if (bad != 0) p = ~p;
                  fmt = {(pm == 0) ? 2'd0 : 2'(pm - 1), (pm != 0), 1'b0, 2'(len)};
                  b = 16'hFFFF;
                  b[0] = 1'b0;
                  for (int i = 0; i < n; i++) b[1+i] = d[i];
                  if (pm != 0) b[n+1] = p;
                  cnt = 1 + n + ((pm != 0) ? 1 : 0) + 3;
                  send_bits(b, cnt);
                  chk((pm >= 3) ? "R4 data" : "R2 data", {24'b0, rx_data}, {24'b0, d});
                  chk((pm >= 3) ? "R4 byte flags" : "R3 byte flags", {29'b0, byte_err}, {31'b0, bad[0]});
                  chk("R3 status", {27'b0, line_status}, {27'b0, 1'b0, 1'b0, bad[0], 1'b0, 1'b1});
                  pop_clear();
                  chk("R10 R11 status after read", {27'b0, line_status}, 32'd0);
               end
            end
         end
      end

      // R5 framing error, 8 bits no parity
      fmt = 6'b000011;
      send_byte8(8'hA5, 1'b0);
      chk("R5 data", {24'b0, rx_data}, 32'hA5);
      chk("R5 byte flags", {29'b0, byte_err}, 32'b010);
      chk("R5 status", {27'b0, line_status}, 32'b01001);
      pop_clear();

      // R6 break, then R12 stays quiet while low
      hold_level(1'b0, 12 * BIT_CLKS);
      chk("R6 data", {24'b0, rx_data}, 32'h00);
      chk("R6 byte flags", {29'b0, byte_err}, 32'b110);
      chk("R6 status", {27'b0, line_status}, 32'b11001);
      pop_clear();
      hold_level(1'b0, 12 * BIT_CLKS);
      chk("R12 no start while low", {31'b0, rx_valid}, 32'd0);
      hold_level(1'b1, 2 * BIT_CLKS);
      send_byte8(8'h5C, 1'b1);
      chk("R12 receives after high", {24'b0, rx_data}, 32'h5C);
      pop_clear();

      // R7 two stop bits: low through first stop only
      fmt = 6'b000111;
      hold_level(1'b0, 10 * BIT_CLKS);
      hold_level(1'b1, 3 * BIT_CLKS);
      chk("R7 two-stop flags", {29'b0, byte_err}, 32'b010);
      pop_clear();

      // R7 5-bit one-and-a-half stop
      fmt = 6'b000100;
      hold_level(1'b0, 7 * BIT_CLKS + BIT_CLKS / 2);
      hold_level(1'b1, 3 * BIT_CLKS);
      chk("R7 1.5 stop break", {29'b0, byte_err}, 32'b110);
      pop_clear();
      hold_level(1'b0, 7 * BIT_CLKS);
      hold_level(1'b1, 3 * BIT_CLKS);
      chk("R7 1.5 stop high tail", {29'b0, byte_err}, 32'b010);
      pop_clear();
      fmt = 6'b000000;
      hold_level(1'b0, 7 * BIT_CLKS);
      hold_level(1'b1, 3 * BIT_CLKS);
      chk("R6 one stop 5-bit break", {29'b0, byte_err}, 32'b110);
      pop_clear();

      // R8 short glitch
      fmt = 6'b000011;
      hold_level(1'b0, 16);
      hold_level(1'b1, 3 * BIT_CLKS);
      chk("R8 glitch valid", {31'b0, rx_valid}, 32'd0);
      chk("R8 glitch status", {27'b0, line_status}, 32'd0);

      // R9 overrun
      send_byte8(8'h11, 1'b1);
      send_byte8(8'h22, 1'b1);
      chk("R9 newest byte kept", {24'b0, rx_data}, 32'h22);
      chk("R9 status", {27'b0, line_status}, 32'b00011);
      pop_clear();
      chk("R9 cleared", {27'b0, line_status}, 32'd0);

      // R11 status read in the completion cycle
      fork
         send_byte8(8'h3C, 1'b0);
         begin
            rd_status = 1'b1;
            while (!rx_valid) @(negedge clk);
            rd_status = 1'b0;
            chk("R11 error survives same-cycle read", {27'b0, line_status}, 32'b01001);
         end
      join
      rd_status = 1'b1;
      @(negedge clk);
      rd_status = 1'b0;
      chk("R11 later read clears", {27'b0, line_status}, 32'b00001);
      rd_byte = 1'b1;
      @(negedge clk);
      rd_byte = 1'b0;
      chk("R10 byte read", {31'b0, rx_valid}, 32'd0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule